// File: doc/BRIEF.md
# Context-Tagged Translation Lookaside Buffer

This block is a small, fully associative store of recent virtual-page to physical-frame translations for one core's memory pipeline. Each entry holds a virtual page number, the frame number it maps to, two permission bits (writeable, user-accessible) and the 12-bit identifier of the address space that installed it. A lookup presents a page number and gets back hit, frame and permissions in the same cycle, compared against the active address-space identifier held inside the block. On a miss the requester runs a page walk and hands the result to the fill port. The block does not walk tables itself.

Since entries are tagged with their address space, a context switch only loads a new identifier, and translations of other processes stay resident. A legacy mode turns tagging off. Identifiers are then not compared, and a write of the page-table base register empties the whole buffer. Software can also drop one address space's entries, or all entries, with explicit commands.

Top module: `tlb_ctx`

## Requirements
- R1: While `rst_ni` is low and after it rises, no entry is valid: every lookup misses with frame and permission outputs at zero.
- R2: A lookup hits in the same cycle when an entry is valid, its page number equals `lk_vpn_i` and, in tagged mode (`tag_en_i`=1), its identifier equals the active identifier. The stored frame is driven on `lk_pfn_o`, writeable on `lk_wr_o` and user on `lk_usr_o`.
- R3: On a miss `lk_hit_o` is 0 and `lk_pfn_o`, `lk_wr_o`, `lk_usr_o` are all 0, which tells the requester to start a walk.
- R4: A fill (`fill_valid_i`=1) installs its page, frame and permissions under the active identifier. From the next cycle on, lookups of that page hit.
- R5: `ctx_set_i` loads `ctx_val_i` as the active identifier from the next cycle on. Loading it invalidates no entry, so returning to an earlier identifier hits on that identifier's entries again.
- R6: With `tag_en_i`=0, identifiers are ignored on lookup and fill, and `base_wr_i` invalidates every entry. With `tag_en_i`=1, `base_wr_i` has no effect.
- R7: `inv_ctx_i` invalidates exactly the entries whose identifier equals `inv_ctx_id_i`. Entries of other identifiers keep hitting.
- R8: `inv_all_i` invalidates every entry.
- R9: A fill goes to the lowest-numbered invalid entry when one exists. When the buffer is full it replaces the entry at a round-robin pointer, which starts at entry 0 after reset and steps by one, wrapping, after each such replacement. With 16 entries filled in order, the 17th fill evicts the first-filled page and the 18th evicts the second.
- R10: A fill whose page and identifier match a valid entry rewrites that entry in place. No second copy is made and no other entry is evicted.
- R11: Invalidation takes priority. A fill in the same cycle as `inv_all_i`, `inv_ctx_i` or a legacy base write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tag_en_i | input | 1 | 1: compare identifiers; 0: legacy mode |
| ctx_set_i | input | 1 | Load a new active identifier |
| ctx_val_i | input | 12 | Identifier to load |
| base_wr_i | input | 1 | Page-table base register written |
| inv_all_i | input | 1 | Invalidate all entries |
| inv_ctx_i | input | 1 | Invalidate entries of one identifier |
| inv_ctx_id_i | input | 12 | Identifier for `inv_ctx_i` |
| lk_vpn_i | input | 36 | Lookup virtual page number |
| lk_hit_o | output | 1 | Lookup hit |
| lk_pfn_o | output | 28 | Frame number on hit, else 0 |
| lk_wr_o | output | 1 | Writeable permission on hit, else 0 |
| lk_usr_o | output | 1 | User permission on hit, else 0 |
| fill_valid_i | input | 1 | Install a walked translation |
| fill_vpn_i | input | 36 | Page number to install |
| fill_pfn_i | input | 28 | Frame number to install |
| fill_wr_i | input | 1 | Writeable bit to install |
| fill_usr_i | input | 1 | User bit to install |

## Verification
The assertions assume that at most one entry matches any lookup. That holds only while the inputs never leave two valid entries with the same page that both match: legacy mode must not be entered while one page is cached under several identifiers. The stimulus keeps every page unique across identifiers before it clears `tag_en_i`, and it flushes before it mixes modes again. The checks also assume that fills carry a page the requester actually missed on. The bench follows this, except for the deliberate duplicate fill that exercises in-place rewrite.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int unsigned TLB_ENTRIES = 16;
  parameter int unsigned TLB_VPN_W   = 36;
  parameter int unsigned TLB_PFN_W   = 28;
  parameter int unsigned TLB_CTX_W   = 12;

  typedef struct packed {
    logic wr;
    logic usr;
  } perm_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int unsigned N     = 16,
  parameter int unsigned VPN_W = 36,
  parameter int unsigned CTX_W = 12,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     valid_i,
  input  logic [VPN_W-1:0] vpn_i [N],
  input  logic [CTX_W-1:0] ctx_i [N],
  input  logic [VPN_W-1:0] key_vpn_i,
  input  logic [CTX_W-1:0] key_ctx_i,
  input  logic             tag_en_i,
  output logic [N-1:0]     hit_vec_o,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec_o[g] = valid_i[g] && (vpn_i[g] == key_vpn_i) &&
                          (!tag_en_i || (ctx_i[g] == key_ctx_i));
  end

  assign any_o = |hit_vec_o;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec_o[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned N = 16,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     valid_i,
  input  logic             adv_i,
  output logic             full_o,
  output logic [IDX_W-1:0] victim_o
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;

  assign full_o = &valid_i;

  // lowest free slot
  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) free_idx = IDX_W'(i);
    end
  end

  assign victim_o = full_o ? rr_q : free_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (adv_i) begin
      rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int unsigned N     = 16,
  parameter int unsigned VPN_W = 36,
  parameter int unsigned PFN_W = 28,
  parameter int unsigned CTX_W = 12,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [VPN_W-1:0]    wr_vpn_i,
  input  logic [PFN_W-1:0]    wr_pfn_i,
  input  logic [CTX_W-1:0]    wr_ctx_i,
  input  tlb_pkg::perm_t      wr_perm_i,
  input  logic                clr_all_i,
  input  logic                clr_ctx_i,
  input  logic [CTX_W-1:0]    clr_ctx_id_i,
  output logic [N-1:0]        valid_o,
  output logic [VPN_W-1:0]    vpn_o  [N],
  output logic [PFN_W-1:0]    pfn_o  [N],
  output logic [CTX_W-1:0]    ctx_o  [N],
  output tlb_pkg::perm_t      perm_o [N]
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    logic sel;
    logic drop;
    assign sel  = wr_en_i && (wr_idx_i == IDX_W'(g));
    assign drop = clr_all_i || (clr_ctx_i && (ctx_o[g] == clr_ctx_id_i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[g] <= 1'b0;
        vpn_o[g]   <= '0;
        pfn_o[g]   <= '0;
        ctx_o[g]   <= '0;
        perm_o[g]  <= '0;
      end else if (drop) begin
        valid_o[g] <= 1'b0;
      end else if (sel) begin
        valid_o[g] <= 1'b1;
        vpn_o[g]   <= wr_vpn_i;
        pfn_o[g]   <= wr_pfn_i;
        ctx_o[g]   <= wr_ctx_i;
        perm_o[g]  <= wr_perm_i;
      end
    end
  end
endmodule

// File: rtl/tlb_ctx.sv
module tlb_ctx
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = TLB_ENTRIES,
  parameter int unsigned VPN_W   = TLB_VPN_W,
  parameter int unsigned PFN_W   = TLB_PFN_W,
  parameter int unsigned CTX_W   = TLB_CTX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tag_en_i,
  input  logic             ctx_set_i,
  input  logic [CTX_W-1:0] ctx_val_i,
  input  logic             base_wr_i,
  input  logic             inv_all_i,
  input  logic             inv_ctx_i,
  input  logic [CTX_W-1:0] inv_ctx_id_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output logic             lk_hit_o,
  output logic [PFN_W-1:0] lk_pfn_o,
  output logic             lk_wr_o,
  output logic             lk_usr_o,
  input  logic             fill_valid_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PFN_W-1:0] fill_pfn_i,
  input  logic             fill_wr_i,
  input  logic             fill_usr_i
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  logic [CTX_W-1:0] ctx_q;
  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [CTX_W-1:0]   tag_q  [ENTRIES];
  perm_t              perm_q [ENTRIES];

  logic [ENTRIES-1:0] lk_vec, fill_vec;
  logic               lk_any, fill_dup;
  logic [IDX_W-1:0]   lk_idx, dup_idx, victim_idx, wr_idx;
  logic               full, flush_all, fill_go, rr_adv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctx_q <= '0;
    else if (ctx_set_i) ctx_q <= ctx_val_i;
  end

  assign flush_all = inv_all_i || (base_wr_i && !tag_en_i);
  assign fill_go   = fill_valid_i && !flush_all && !inv_ctx_i;
  assign wr_idx    = fill_dup ? dup_idx : victim_idx;
  assign rr_adv    = fill_go && !fill_dup && full;

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .CTX_W(CTX_W)) u_lk_match (
    .valid_i   (valid_q),
    .vpn_i     (vpn_q),
    .ctx_i     (tag_q),
    .key_vpn_i (lk_vpn_i),
    .key_ctx_i (ctx_q),
    .tag_en_i  (tag_en_i),
    .hit_vec_o (lk_vec),
    .any_o     (lk_any),
    .idx_o     (lk_idx)
  );

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .CTX_W(CTX_W)) u_fill_match (
    .valid_i   (valid_q),
    .vpn_i     (vpn_q),
    .ctx_i     (tag_q),
    .key_vpn_i (fill_vpn_i),
    .key_ctx_i (ctx_q),
    .tag_en_i  (tag_en_i),
    .hit_vec_o (fill_vec),
    .any_o     (fill_dup),
    .idx_o     (dup_idx)
  );

  tlb_victim #(.N(ENTRIES)) u_victim (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_q),
    .adv_i    (rr_adv),
    .full_o   (full),
    .victim_o (victim_idx)
  );

  tlb_store #(.N(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .CTX_W(CTX_W)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (fill_go),
    .wr_idx_i     (wr_idx),
    .wr_vpn_i     (fill_vpn_i),
    .wr_pfn_i     (fill_pfn_i),
    .wr_ctx_i     (ctx_q),
    .wr_perm_i    ('{wr: fill_wr_i, usr: fill_usr_i}),
    .clr_all_i    (flush_all),
    .clr_ctx_i    (inv_ctx_i),
    .clr_ctx_id_i (inv_ctx_id_i),
    .valid_o      (valid_q),
    .vpn_o        (vpn_q),
    .pfn_o        (pfn_q),
    .ctx_o        (tag_q),
    .perm_o       (perm_q)
  );

  assign lk_hit_o = lk_any;
  assign lk_pfn_o = lk_any ? pfn_q[lk_idx] : '0;
  assign lk_wr_o  = lk_any && perm_q[lk_idx].wr;
  assign lk_usr_o = lk_any && perm_q[lk_idx].usr;
endmodule

// File: rtl/tlb_ctx_chk.sv
module tlb_ctx_chk #(
  parameter int unsigned N = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] valid_q,
  input logic [N-1:0] lk_vec,
  input logic         fill_dup,
  input logic         fill_valid_i,
  input logic         inv_all_i,
  input logic         inv_ctx_i,
  input logic         base_wr_i,
  input logic         tag_en_i,
  input logic         ctx_set_i
);
  logic legacy_flush;
  assign legacy_flush = base_wr_i && !tag_en_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) assert_reset_empty_R1: assert (valid_q == '0);
  end

  assert_single_hit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_vec));

  assert_fill_adds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !fill_dup && !(&valid_q) && !inv_all_i && !inv_ctx_i && !legacy_flush)
    |=> $countones(valid_q) == $past($countones(valid_q)) + 1);

  assert_ctx_keep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctx_set_i && !fill_valid_i && !inv_all_i && !inv_ctx_i && !base_wr_i)
    |=> valid_q == $past(valid_q));

  assert_legacy_flush_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legacy_flush |=> valid_q == '0);

  assert_tagged_base_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_wr_i && tag_en_i && !fill_valid_i && !inv_all_i && !inv_ctx_i)
    |=> valid_q == $past(valid_q));

  assert_inv_all_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_all_i |=> valid_q == '0);

  assert_dup_inplace_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && fill_dup && !inv_all_i && !inv_ctx_i && !legacy_flush)
    |=> valid_q == $past(valid_q));

  assert_fill_dropped_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && inv_ctx_i)
    |=> $countones(valid_q) <= $past($countones(valid_q)));
endmodule

bind tlb_ctx tlb_ctx_chk #(.N(ENTRIES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_q      (valid_q),
  .lk_vec       (lk_vec),
  .fill_dup     (fill_dup),
  .fill_valid_i (fill_valid_i),
  .inv_all_i    (inv_all_i),
  .inv_ctx_i    (inv_ctx_i),
  .base_wr_i    (base_wr_i),
  .tag_en_i     (tag_en_i),
  .ctx_set_i    (ctx_set_i)
);

// File: tb/tb_tlb_ctx.sv
module tb_tlb_ctx;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tag_en_i = 1'b1, ctx_set_i = 1'b0, base_wr_i = 1'b0;
  logic        inv_all_i = 1'b0, inv_ctx_i = 1'b0;
  logic [11:0] ctx_val_i = '0, inv_ctx_id_i = '0;
  logic [35:0] lk_vpn_i = '0, fill_vpn_i = '0;
  logic [27:0] lk_pfn_o, fill_pfn_i = '0;
  logic        lk_hit_o, lk_wr_o, lk_usr_o;
  logic        fill_valid_i = 1'b0, fill_wr_i = 1'b0, fill_usr_i = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #4 clk_i = ~clk_i;

  tlb_ctx dut (.*);

  typedef struct packed {
    logic        is_fill;
    logic [35:0] vpn;
    logic [27:0] pfn;
    logic        wr;
    logic        usr;
    logic        hit;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 36'h1000, 28'hAAA, 1'b1, 1'b0, 1'b0},
    '{1'b0, 36'h1000, 28'hAAA, 1'b1, 1'b0, 1'b1},
    '{1'b0, 36'h1001, 28'h0,   1'b0, 1'b0, 1'b0},
    '{1'b1, 36'h2222, 28'h55,  1'b0, 1'b1, 1'b0},
    '{1'b0, 36'h2222, 28'h55,  1'b0, 1'b1, 1'b1},
    '{1'b1, 36'h1000, 28'hBBB, 1'b0, 1'b1, 1'b0},
    '{1'b0, 36'h1000, 28'hBBB, 1'b0, 1'b1, 1'b1}
  };

  task automatic lookup(input logic [35:0] vpn, input logic hit, input logic [27:0] pfn,
                        input logic wr, input logic usr, input string tag);
    @(negedge clk_i);
    lk_vpn_i = vpn;
    #2;
    checks++;
    if ({lk_hit_o, lk_pfn_o, lk_wr_o, lk_usr_o} !== {hit, pfn, wr, usr}) begin
      fails++;
      $display("FAIL %s vpn=%h actual hit=%b pfn=%h wr=%b usr=%b expected hit=%b pfn=%h wr=%b usr=%b",
               tag, vpn, lk_hit_o, lk_pfn_o, lk_wr_o, lk_usr_o, hit, pfn, wr, usr);
    end
  endtask

  task automatic fill(input logic [35:0] vpn, input logic [27:0] pfn, input logic wr, input logic usr);
    @(negedge clk_i);
    fill_valid_i = 1'b1; fill_vpn_i = vpn; fill_pfn_i = pfn; fill_wr_i = wr; fill_usr_i = usr;
    @(negedge clk_i);
    fill_valid_i = 1'b0;
  endtask

  task automatic set_ctx(input logic [11:0] c);
    @(negedge clk_i);
    ctx_set_i = 1'b1; ctx_val_i = c;
    @(negedge clk_i);
    ctx_set_i = 1'b0;
  endtask

  task automatic pulse_inv_all();
    @(negedge clk_i);
    inv_all_i = 1'b1;
    @(negedge clk_i);
    inv_all_i = 1'b0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1;
    checks++;
    if ({lk_hit_o, lk_pfn_o, lk_wr_o, lk_usr_o} !== '0) begin
      fails++;
      $display("FAIL R1 in reset actual %b expected 0", {lk_hit_o, lk_pfn_o, lk_wr_o, lk_usr_o});
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    lookup(36'h0, 1'b0, '0, 1'b0, 1'b0, "R1 after reset");
    lookup(36'h1000, 1'b0, '0, 1'b0, 1'b0, "R1 R3 empty miss");

    // vector table: R2 R3 R4 R10
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_fill) fill(VECS[i].vpn, VECS[i].pfn, VECS[i].wr, VECS[i].usr);
      else lookup(VECS[i].vpn, VECS[i].hit, VECS[i].pfn, VECS[i].wr, VECS[i].usr, "R2 R3 R4 R10 vector");
    end

    // R9 R10: slots 0,1 used; fill 14 more to fill all 16
    for (int k = 0; k < 14; k++) fill(36'h5000 + 36'(k), 28'h100 + 28'(k), 1'b0, 1'b0);
    lookup(36'h1000, 1'b1, 28'hBBB, 1'b0, 1'b1, "R10 no duplicate, still resident");
    fill(36'h7777, 28'h777, 1'b1, 1'b1);
    lookup(36'h1000, 1'b0, '0, 1'b0, 1'b0, "R9 17th fill evicts first");
    lookup(36'h2222, 1'b1, 28'h55, 1'b0, 1'b1, "R9 second kept");
    lookup(36'h7777, 1'b1, 28'h777, 1'b1, 1'b1, "R9 new entry");
    fill(36'h8888, 28'h888, 1'b0, 1'b0);
    lookup(36'h2222, 1'b0, '0, 1'b0, 1'b0, "R9 18th fill evicts second");
    lookup(36'h5000, 1'b1, 28'h100, 1'b0, 0, "R9 third kept");

    // R5 R2 context tagging
    set_ctx(12'd5);
    lookup(36'h7777, 1'b0, '0, 1'b0, 1'b0, "R2 other context misses");
    fill(36'h7777, 28'hC5C, 1'b0, 1'b1);
    lookup(36'h7777, 1'b1, 28'hC5C, 1'b0, 1'b1, "R4 fill under ctx 5");
    set_ctx(12'd0);
    lookup(36'h7777, 1'b1, 28'h777, 1'b1, 1'b1, "R5 ctx 0 entry kept");
    set_ctx(12'd5);
    lookup(36'h7777, 1'b1, 28'hC5C, 1'b0, 1'b1, "R5 ctx 5 entry kept");

    // R7 per-context invalidate
    @(negedge clk_i);
    inv_ctx_i = 1'b1; inv_ctx_id_i = 12'd5;
    @(negedge clk_i);
    inv_ctx_i = 1'b0;
    lookup(36'h7777, 1'b0, '0, 1'b0, 1'b0, "R7 ctx 5 cleared");
    set_ctx(12'd0);
    lookup(36'h7777, 1'b1, 28'h777, 1'b1, 1'b1, "R7 ctx 0 survives");

    // R6 tagged base write has no effect
    @(negedge clk_i);
    base_wr_i = 1'b1;
    @(negedge clk_i);
    base_wr_i = 1'b0;
    lookup(36'h7777, 1'b1, 28'h777, 1'b1, 1'b1, "R6 tagged base write ignored");

    // R6 legacy mode
    @(negedge clk_i);
    tag_en_i = 1'b0;
    set_ctx(12'd7);
    lookup(36'h7777, 1'b1, 28'h777, 1'b1, 1'b1, "R6 legacy ignores context");
    @(negedge clk_i);
    base_wr_i = 1'b1;
    @(negedge clk_i);
    base_wr_i = 1'b0;
    lookup(36'h7777, 1'b0, '0, 1'b0, 1'b0, "R6 legacy base write flush");
    lookup(36'h8888, 1'b0, '0, 1'b0, 1'b0, "R6 legacy flush all");
    @(negedge clk_i);
    tag_en_i = 1'b1;

    // R8 global invalidate
    fill(36'h9999, 28'h999, 1'b1, 1'b0);
    lookup(36'h9999, 1'b1, 28'h999, 1'b1, 1'b0, "R4 fill under ctx 7");
    pulse_inv_all();
    lookup(36'h9999, 1'b0, '0, 1'b0, 1'b0, "R8 global invalidate");

    // R11 fill dropped with invalidate
    @(negedge clk_i);
    fill_valid_i = 1'b1; fill_vpn_i = 36'hAAAA; fill_pfn_i = 28'hAAA; inv_all_i = 1'b1;
    @(negedge clk_i);
    fill_valid_i = 1'b0; inv_all_i = 1'b0;
    lookup(36'hAAAA, 1'b0, '0, 1'b0, 1'b0, "R11 fill with inv_all dropped");
    @(negedge clk_i);
    fill_valid_i = 1'b1; fill_vpn_i = 36'hBBBB; fill_pfn_i = 28'hBBB;
    inv_ctx_i = 1'b1; inv_ctx_id_i = 12'd3;
    @(negedge clk_i);
    fill_valid_i = 1'b0; inv_ctx_i = 1'b0;
    lookup(36'hBBBB, 1'b0, '0, 1'b0, 1'b0, "R11 fill with inv_ctx dropped");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule